// File: doc/BRIEF.md
# Condition code flag unit

This block holds the eight-bit condition code byte of a small processor and updates its arithmetic flags from one ALU operation. Each cycle it receives the two operands, the raw result, which is one bit wider than the operation, and a width select that picks 8-bit or 16-bit arithmetic. It derives the half-carry, negative, zero, overflow and carry conditions from these inputs.

Per-flag update enables decide which conditions may reach the register. An update can only raise a flag and never lowers one. An instruction that needs fresh flags first clears them through a clear mask, and that clear acts in the same cycle, ahead of the updates. A parallel load replaces the whole byte at once, for example when the byte is restored from a stack. The packed byte and each flag are available as outputs.

Top module: `ccr_flag_unit`

## Requirements
- R1: After a synchronous active-high reset the byte `cc` reads 0x00.
- R2: When `load` is high, the next `cc` equals `load_val`, whatever `clr_mask` and `upd` hold in that cycle.
- R3: When `upd[4]` is high, bit 5 of `cc` (half-carry) is set if bit 4 of `a ^ b ^ res` is 1. This holds in both widths.
- R4: When `upd[1]` is high, bit 1 of `cc` (overflow) is set if the selected bit of `a ^ b ^ res ^ (res >> 1)` is 1. The selected bit is bit 7 with `wide`=0 and bit 15 with `wide`=1.
- R5: When `upd[0]` is high, bit 0 of `cc` (carry) is set from `res[8]` with `wide`=0 and from `res[16]` with `wide`=1.
- R6: When `upd[3]` is high, bit 3 of `cc` (negative) is set from `res[7]` with `wide`=0 and from `res[15]` with `wide`=1.
- R7: When `upd[2]` is high, bit 2 of `cc` (zero) is set if `res[7:0]` is all zero with `wide`=0, or if `res[15:0]` is all zero with `wide`=1.
- R8: Updates are sticky. A flag already at 1 and not cleared stays 1 whatever the result, and a flag whose enable is low is unchanged.
- R9: Bits selected by `clr_mask` are cleared in the same cycle before the updates apply. A bit that is both cleared and set ends at 1.
- R10: The layout from bit 7 down to bit 0 is E, F, H, I, N, Z, V, C, and each `f_*` output equals its bit of `cc`. E, F and I change only through load, clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 16 | Operand a |
| b | input | 16 | Operand b |
| res | input | 17 | Unmasked ALU result |
| wide | input | 1 | 1 selects 16-bit mode, 0 selects 8-bit mode |
| upd | input | 5 | Update enables: [4]=H, [3]=N, [2]=Z, [1]=V, [0]=C |
| clr_mask | input | 8 | Bits of `cc` to clear this cycle |
| load | input | 1 | Load the whole byte from `load_val` |
| load_val | input | 8 | Byte to load |
| cc | output | 8 | Packed condition code byte |
| f_e | output | 1 | Bit 7, entire state |
| f_f | output | 1 | Bit 6, fast interrupt mask |
| f_h | output | 1 | Bit 5, half-carry |
| f_i | output | 1 | Bit 4, interrupt mask |
| f_n | output | 1 | Bit 3, negative |
| f_z | output | 1 | Bit 2, zero |
| f_v | output | 1 | Bit 1, overflow |
| f_c | output | 1 | Bit 0, carry |

## Verification
Two actions can meet on one bit in the same cycle: a clear from `clr_mask` and a set from an enabled update. A load can also arrive together with clears and updates. The bench drives cycles that clear every flag while the result would set some of them, and cycles that assert `load` with every enable high. A behavioural model that clears first, then sets, and lets the load win judges the byte after every edge.

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit #(
  parameter int WIDE   = 16,
  parameter int NARROW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WIDE-1:0] a,
  input  logic [WIDE-1:0] b,
  input  logic [WIDE:0]   res,
  input  logic            wide,
  input  logic [4:0]      upd,
  input  logic [7:0]      clr_mask,
  input  logic            load,
  input  logic [7:0]      load_val,
  output logic [7:0]      cc,
  output logic            f_e,
  output logic            f_f,
  output logic            f_h,
  output logic            f_i,
  output logic            f_n,
  output logic            f_z,
  output logic            f_v,
  output logic            f_c
);
  localparam int HBIT = 4;

  logic [WIDE:0] mix;
  logic          h_cond, n_cond, z_cond, v_cond, c_cond;
  logic [7:0]    sets;

  assign mix    = {1'b0, a ^ b} ^ res ^ (res >> 1);
  assign h_cond = mix[HBIT] ^ res[HBIT+1];
  assign v_cond = wide ? mix[WIDE-1] : mix[NARROW-1];
  assign n_cond = wide ? res[WIDE-1] : res[NARROW-1];
  assign c_cond = wide ? res[WIDE]   : res[NARROW];
  assign z_cond = wide ? ~|res[WIDE-1:0] : ~|res[NARROW-1:0];

  assign sets = {2'b00, upd[4] & h_cond, 1'b0,
                 upd[3] & n_cond, upd[2] & z_cond,
                 upd[1] & v_cond, upd[0] & c_cond};

  always_ff @(posedge clk) begin
    if (rst)       cc <= 8'h00;
    else if (load) cc <= load_val;
    else           cc <= (cc & ~clr_mask) | sets;
  end

  assign {f_e, f_f, f_h, f_i, f_n, f_z, f_v, f_c} = cc;
endmodule

// File: rtl/ccr_flag_unit_chk.sv
module ccr_flag_unit_chk #(
  parameter int WIDE = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      upd,
  input logic [7:0]      clr_mask,
  input logic            load,
  input logic [7:0]      load_val,
  input logic [7:0]      cc,
  input logic            f_e,
  input logic            f_f,
  input logic            f_h,
  input logic            f_i,
  input logic            f_n,
  input logic            f_z,
  input logic            f_v,
  input logic            f_c
);
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cc == 8'h00);

  a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> cc == $past(load_val));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((cc & $past(cc) & ~$past(clr_mask)) == ($past(cc) & ~$past(clr_mask))));

  a_r9_clear_only: assert property (@(posedge clk) disable iff (rst)
    (!load && upd == 5'd0) |=> cc == ($past(cc) & ~$past(clr_mask)));

  a_r10_efi_no_rise: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((cc & ~$past(cc) & 8'hD0) == 8'h00));

  a_r10_layout: assert property (@(posedge clk) disable iff (rst)
    cc == {f_e, f_f, f_h, f_i, f_n, f_z, f_v, f_c});
endmodule

bind ccr_flag_unit ccr_flag_unit_chk #(.WIDE(WIDE)) chk_i (.*);

// File: tb/ccr_flag_unit_tb.sv
module ccr_flag_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] a, b;
  logic [16:0] res;
  logic        wide;
  logic [4:0]  upd;
  logic [7:0]  clr_mask;
  logic        load;
  logic [7:0]  load_val;
  logic [7:0]  cc;
  logic        f_e, f_f, f_h, f_i, f_n, f_z, f_v, f_c;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_flag_unit dut_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .res(res), .wide(wide), .upd(upd),
    .clr_mask(clr_mask), .load(load), .load_val(load_val), .cc(cc),
    .f_e(f_e), .f_f(f_f), .f_h(f_h), .f_i(f_i),
    .f_n(f_n), .f_z(f_z), .f_v(f_v), .f_c(f_c)
  );

  function automatic int next_cc(int cur, int ia, int ib, int ir, bit w,
                                 int u, int clr, bit ld, int lv);
    int m, vb;
    if (ld) return lv;
    m  = cur & ~clr & 255;
    vb = w ? 15 : 7;
    if (u[4] && (((ia ^ ib ^ ir) >> 4) & 1) != 0) m = m | 32;
    if (u[3] && ((ir >> vb) & 1) != 0) m = m | 8;
    if (u[2] && (ir & (w ? 65535 : 255)) == 0) m = m | 4;
    if (u[1] && (((ia ^ ib ^ ir ^ (ir >> 1)) >> vb) & 1) != 0) m = m | 2;
    if (u[0] && ((ir >> (w ? 16 : 8)) & 1) != 0) m = m | 1;
    return m;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (cc !== model[7:0] ||
        {f_e, f_f, f_h, f_i, f_n, f_z, f_v, f_c} !== model[7:0]) begin
      fails++;
      $display("FAIL %s: cc=%02h flags=%08b expected %02h", tag, cc,
               {f_e, f_f, f_h, f_i, f_n, f_z, f_v, f_c}, model[7:0]);
    end
  endtask

  task automatic step(string tag, int ia, int ib, int ir, bit w, int u,
                      int clr, bit ld, int lv);
    @(negedge clk);
    a = ia[15:0]; b = ib[15:0]; res = ir[16:0]; wide = w;
    upd = u[4:0]; clr_mask = clr[7:0]; load = ld; load_val = lv[7:0];
    model = next_cc(model, ia & 65535, ib & 65535, ir & 131071, w, u, clr, ld, lv & 255);
    @(posedge clk); #1;
    compare(tag);
  endtask

  initial begin
    rst = 1; a = 0; b = 0; res = 0; wide = 0; upd = 0; clr_mask = 0;
    load = 0; load_val = 0;
    repeat (3) @(posedge clk);
    #1; model = 0; compare("R1");
    @(negedge clk); rst = 0;

    step("R2", 0, 0, 0, 0, 31, 255, 1, 'hA5);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 'h0F, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R3", 'h08, 'h08, 'h010, 0, 16, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R3", 'h0F, 'h01, 'h010, 1, 16, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R3", 'h01, 'h01, 'h002, 0, 16, 0, 0, 0);
    step("R4", 'h7F, 'h01, 'h080, 0, 2, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R4", 'h7F, 'h01, 'h080, 1, 2, 0, 0, 0);
    step("R4", 'h7FFF, 'h0001, 'h08000, 1, 2, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R5", 'hFF, 'h01, 'h100, 0, 1, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R5", 'hFF, 'h01, 'h100, 1, 1, 0, 0, 0);
    step("R5", 'hFFFF, 'h0001, 'h10000, 1, 1, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R6", 0, 0, 'h0080, 0, 8, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R6", 0, 0, 'h0080, 1, 8, 0, 0, 0);
    step("R6", 0, 0, 'h8000, 1, 8, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R7", 0, 0, 'h1100, 0, 4, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 255, 0, 0);
    step("R7", 0, 0, 'h1100, 1, 4, 0, 0, 0);
    step("R7", 0, 0, 'h10000, 1, 4, 0, 0, 0);
    step("R8", 0, 0, 'h00001, 1, 31, 0, 0, 0);
    step("R8", 'h0F, 'h01, 'h18110, 0, 0, 0, 0, 0);
    step("R9", 'hFF, 'h01, 'h100, 0, 31, 255, 0, 0);
    step("R2", 'hFF, 'h01, 'h100, 0, 31, 255, 1, 'h50);
    step("R10", 'hFF, 'h01, 'h100, 0, 31, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int ra, rb, rr, ru, rc, rl, rv;
      ra = $urandom & 65535; rb = $urandom & 65535; rr = $urandom & 131071;
      if ((i % 7) == 0) rr = rr & 'h10000;
      ru = $urandom & 31;
      rc = ((i % 3) == 0) ? ($urandom & 255) : 0;
      rl = ((i % 23) == 0) ? 1 : 0;
      rv = $urandom & 255;
      step("R8", ra, rb, rr, i[0], ru, rc, rl[0], rv);
    end

    @(negedge clk); rst = 1;
    @(posedge clk); #1; model = 0; compare("R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: R1 run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule